// File: doc/BRIEF.md
# Daisy-Chain Converter Serial Port

This block is the serial side of one 18-bit sampling converter built to sit in a chain of identical converters that share one convert strobe and one serial clock. Each converter's serial output feeds the serial input of the next one. The last converter's output goes to a host. The host raises the convert strobe while the serial clock is high. This starts a conversion in every device and puts each one in chain mode with a busy indicator. A plain cycle counter stands in for the analog conversion time. When the counter expires, the result on the parallel sample input is latched into an internal shift register.

Each device drives its serial output with its own done flag ANDed with its serial input. The first device in the chain has its serial input tied to the convert strobe. The output of the last device therefore goes high only after every converter has finished, and the host can use that rising level to start reading. The first falling serial-clock edge after that replaces the done level with the data MSB. Each later falling edge shifts the register towards the output and takes the serial input in at the LSB end. A chain of N devices therefore behaves as one long register and is read with 18·N+1 falling edges. Dropping the convert strobe ends the session and returns the device to acquisition.

Top module: `chain_adc_port`

## Requirements
- R1: A synchronous reset clears the shift register and returns the port to acquisition. While reset is applied, and afterwards until a conversion starts, sdo is 0.
- R2: In acquisition, with cnv and sdi low, sdo is 0 whatever sck does.
- R3: A rising edge on cnv while sck is high starts a conversion. A rising edge on cnv while sck is low is ignored, and sdo stays 0.
- R4: A conversion lasts CONV_CYCLES clock cycles after the cycle in which the start was detected, and sdo is 0 for that whole time.
- R5: Once its own conversion has ended, and while cnv stays high, the port drives sdo equal to sdi (own done AND sdi). The busy-done level therefore rises only when every upstream device has finished.
- R6: The first sck falling edge after conversion end switches sdo to result bit DATA_W-1. It captures nothing from sdi.
- R7: Each later sck falling edge shifts the register one place towards the MSB, with sdi entering at bit 0. sdo always shows the register MSB, so the result leaves MSB first.
- R8: In a two-device chain, falling edges 1 to 18 deliver the last device's bits MSB first, and edges 19 to 36 deliver the upstream device's bits MSB first. Edge 37 delivers the cnv level (1) that the first device captured.
- R9: Taking cnv low at any point after a start ends the session: on the next clock sdo is 0 and the port is back in acquisition, where sck edges have no effect.
- R10: The parallel sample is latched on the clock that ends the conversion. Later changes on sample do not alter the bits read out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; serial inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cnv | input | 1 | Convert strobe, held high through conversion and readback |
| sck | input | 1 | Serial clock from the host, already synchronous to clk |
| sdi | input | 1 | Chain input from the upstream device's sdo |
| sample | input | DATA_W | Conversion result presented by the converter core |
| sdo | output | 1 | Serial output: busy-done level, then data MSB first |

## Verification
The hardest case to reach is a device that has finished its own conversion while its upstream neighbour is still converting. Only then does the AND in the busy-done level show. The bench creates this by chaining two instances with different conversion lengths. The downstream device finishes ten cycles earlier, and its sdo must stay low until the upstream output rises. The same chained pair is then read with 37 falling edges, so that bits crossing from one register into the other, and the final captured strobe level, are observed at the host end.

// File: rtl/chain_adc_pkg.sv
package chain_adc_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_CONV = 2'd1,
      ST_FLAG = 2'd2,
      ST_READ = 2'd3
   } cadc_state_t;

endpackage

// File: rtl/chain_adc_edge.sv
module chain_adc_edge #(
   parameter bit RISING = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic d,
   output logic pulse
);

   logic d_q;

   always_ff @(posedge clk) begin
      if (rst) d_q <= 1'b0;
      else     d_q <= d;
   end

   generate
      if (RISING) begin : g_rise
         assign pulse = d & ~d_q;
      end else begin : g_fall
         assign pulse = ~d & d_q;
      end
   endgenerate

endmodule

// File: rtl/chain_adc_timer.sv
module chain_adc_timer #(
   parameter int CYCLES = 20
) (
   input  logic clk,
   input  logic rst,
   input  logic start,
   input  logic run,
   output logic done
);

   localparam int CNT_W = (CYCLES < 2) ? 1 : $clog2(CYCLES);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst)
         cnt_q <= '0;
      else if (start)
         cnt_q <= CNT_W'(CYCLES - 1);
      else if (run && cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign done = run && (cnt_q == '0);

endmodule

// File: rtl/chain_adc_shreg.sv
module chain_adc_shreg #(
   parameter int W = 18
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         shift,
   input  logic         ser_in,
   output logic [W-1:0] q
);

   always_ff @(posedge clk) begin
      if (rst)        q <= '0;
      else if (load)  q <= load_val;
      else if (shift) q <= {q[W-2:0], ser_in};
   end

endmodule

// File: rtl/chain_adc_port.sv
module chain_adc_port
   import chain_adc_pkg::*;
#(
   parameter int DATA_W      = 18,
   parameter int CONV_CYCLES = 20
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cnv,
   input  logic              sck,
   input  logic              sdi,
   input  logic [DATA_W-1:0] sample,
   output logic              sdo
);

   localparam int MSB = DATA_W - 1;

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("chain_adc_port: DATA_W must be at least 2");
      end
      if (CONV_CYCLES < 1) begin : g_bad_cycles
         $error("chain_adc_port: CONV_CYCLES must be at least 1");
      end
   endgenerate

   cadc_state_t       state_q, state_d;
   logic              cnv_rise, sck_fall;
   logic              start_en, run_en, conv_done, load_en, shift_en;
   logic [DATA_W-1:0] shreg_q;

   chain_adc_edge #(.RISING(1'b1)) u_cnv_edge (
      .clk   (clk),
      .rst   (rst),
      .d     (cnv),
      .pulse (cnv_rise)
   );

   chain_adc_edge #(.RISING(1'b0)) u_sck_edge (
      .clk   (clk),
      .rst   (rst),
      .d     (sck),
      .pulse (sck_fall)
   );

   assign start_en = (state_q == ST_IDLE) && cnv_rise && sck;
   assign run_en   = (state_q == ST_CONV) && cnv;

   chain_adc_timer #(.CYCLES(CONV_CYCLES)) u_timer (
      .clk   (clk),
      .rst   (rst),
      .start (start_en),
      .run   (run_en),
      .done  (conv_done)
   );

   assign load_en  = run_en && conv_done;
   assign shift_en = (state_q == ST_READ) && cnv && sck_fall;

   chain_adc_shreg #(.W(DATA_W)) u_shreg (
      .clk      (clk),
      .rst      (rst),
      .load     (load_en),
      .load_val (sample),
      .shift    (shift_en),
      .ser_in   (sdi),
      .q        (shreg_q)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: if (start_en) state_d = ST_CONV;
         ST_CONV: begin
            if (!cnv)           state_d = ST_IDLE;
            else if (conv_done) state_d = ST_FLAG;
         end
         ST_FLAG: begin
            if (!cnv)          state_d = ST_IDLE;
            else if (sck_fall) state_d = ST_READ;
         end
         ST_READ: if (!cnv) state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) state_q <= ST_IDLE;
      else     state_q <= state_d;
   end

   always_comb begin
      unique case (state_q)
         ST_FLAG: sdo = sdi;
         ST_READ: sdo = shreg_q[MSB];
         default: sdo = 1'b0;
      endcase
   end

endmodule

// File: rtl/chain_adc_port_chk.sv
module chain_adc_port_chk
   import chain_adc_pkg::*;
#(
   parameter int DATA_W = 18
) (
   input logic              clk,
   input logic              rst,
   input logic              cnv,
   input logic              sck,
   input logic              sdi,
   input logic              sdo,
   input cadc_state_t       state,
   input logic [DATA_W-1:0] shreg
);

   // R2: two sampled lows on cnv leave the port idle with sdo low
   p_idle_low_r2: assert property (@(posedge clk) disable iff (rst)
      (!cnv && $past(!cnv)) |-> !sdo);

   // R3: start only when sck is high at the cnv rise
   p_start_r3: assert property (@(posedge clk) disable iff (rst)
      (state == ST_IDLE && $rose(cnv) && sck) |=> state == ST_CONV);

   p_ignore_r3: assert property (@(posedge clk) disable iff (rst)
      (state == ST_IDLE && $rose(cnv) && !sck) |=> state == ST_IDLE);

   // R4: output held low while converting
   p_conv_low_r4: assert property (@(posedge clk) disable iff (rst)
      (state == ST_CONV) |-> !sdo);

   // R5: busy-done level follows the upstream neighbour
   p_flag_follow_r5: assert property (@(posedge clk) disable iff (rst)
      (state == ST_FLAG) |-> sdo == sdi);

   // R7: a falling sck in readback moves sdi into bit 0
   p_shift_in_r7: assert property (@(posedge clk) disable iff (rst)
      (state == ST_READ && cnv && !sck && $past(sck))
      |=> (shreg[0] == $past(sdi)) && (shreg[DATA_W-1:1] == $past(shreg[DATA_W-2:0])));

   // R9: cnv low ends any session
   p_end_session_r9: assert property (@(posedge clk) disable iff (rst)
      (state != ST_IDLE && !cnv) |=> state == ST_IDLE);

endmodule

bind chain_adc_port chain_adc_port_chk #(.DATA_W(DATA_W)) u_chk (
   .clk   (clk),
   .rst   (rst),
   .cnv   (cnv),
   .sck   (sck),
   .sdi   (sdi),
   .sdo   (sdo),
   .state (state_q),
   .shreg (shreg_q)
);

// File: tb/chain_adc_port_test.sv
module chain_adc_port_test;

   localparam int W       = 18;
   localparam int UUT_CYC = 20;
   localparam int UP_CYC  = 30;
   localparam int NVEC    = 4;

   // each entry: {upstream sample, downstream sample}
   localparam logic [2*W-1:0] VEC [NVEC] = '{
      {18'h3FFFF, 18'h00000},
      {18'h00000, 18'h3FFFF},
      {18'h2D5A3, 18'h1C0F7},
      {18'h20001, 18'h10002}
   };

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic cnv = 1'b0;
   logic sck = 1'b0;
   logic [W-1:0] up_sample  = '0;
   logic [W-1:0] uut_sample = '0;
   logic up_sdo;
   logic sdo;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   // first device: sdi tied to cnv
   chain_adc_port #(.DATA_W(W), .CONV_CYCLES(UP_CYC)) up (
      .clk(clk), .rst(rst), .cnv(cnv), .sck(sck), .sdi(cnv),
      .sample(up_sample), .sdo(up_sdo)
   );

   // last device, nearest the host
   chain_adc_port #(.DATA_W(W), .CONV_CYCLES(UUT_CYC)) uut (
      .clk(clk), .rst(rst), .cnv(cnv), .sck(sck), .sdi(up_sdo),
      .sample(uut_sample), .sdo(sdo)
   );

   task automatic check(input logic ok, input string req,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic sck_pulse(output logic got);
      @(negedge clk) sck = 1'b0;
      @(negedge clk) got = sdo;
      sck = 1'b1;
      @(negedge clk);
   endtask

   task automatic start_conv();
      @(negedge clk) sck = 1'b1;
      @(negedge clk) cnv = 1'b1;
      @(posedge clk);
   endtask

   task automatic run_vector(input logic [W-1:0] us, input logic [W-1:0] ds);
      logic b;
      logic expb;
      up_sample  = us;
      uut_sample = ds;
      start_conv();
      repeat (UUT_CYC) @(posedge clk);
      @(negedge clk);
      check(sdo == 1'b0, "R5 done but upstream busy", 32'(sdo), 0);
      uut_sample = ~ds; // R10: must not reach the output
      repeat (UP_CYC - UUT_CYC - 1) @(posedge clk);
      @(negedge clk);
      check(up_sdo == 1'b0, "R4 upstream still converting", 32'(up_sdo), 0);
      @(posedge clk);
      @(negedge clk);
      check(up_sdo == 1'b1, "R4 upstream conversion end", 32'(up_sdo), 1);
      check(sdo == 1'b1, "R5 chain busy-done", 32'(sdo), 1);
      for (int k = 1; k <= 2 * W + 1; k++) begin
         sck_pulse(b);
         if (k <= W)          expb = ds[W-k];
         else if (k <= 2 * W) expb = us[2*W-k];
         else                 expb = 1'b1;
         if (k == 1)
            check(b == expb, "R6 first fall gives MSB", 32'(b), 32'(expb));
         else if (k <= W)
            check(b == expb, "R7 R10 own bit", 32'(b), 32'(expb));
         else
            check(b == expb, "R8 upstream bit", 32'(b), 32'(expb));
      end
      @(negedge clk) cnv = 1'b0;
      @(negedge clk);
      check(sdo == 1'b0, "R9 session end", 32'(sdo), 0);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : main
      logic b;
      // R1: reset state
      repeat (3) @(negedge clk);
      check(sdo == 1'b0, "R1 reset sdo", 32'(sdo), 0);
      check(up_sdo == 1'b0, "R1 reset upstream sdo", 32'(up_sdo), 0);
      rst = 1'b0;
      @(negedge clk);
      check(sdo == 1'b0, "R1 after reset", 32'(sdo), 0);

      // R2: idle with sck activity
      for (int i = 0; i < 3; i++) begin
         sck_pulse(b);
         check(b == 1'b0, "R2 idle sdo low", 32'(b), 0);
      end

      // R3: cnv rise with sck low is ignored
      @(negedge clk) sck = 1'b0;
      @(negedge clk) cnv = 1'b1;
      repeat (UP_CYC + 10) @(negedge clk);
      check(sdo == 1'b0, "R3 no start with sck low", 32'(sdo), 0);
      check(up_sdo == 1'b0, "R3 upstream no start", 32'(up_sdo), 0);
      @(negedge clk) cnv = 1'b0;
      @(negedge clk);

      // vector table
      for (int v = 0; v < NVEC; v++)
         run_vector(VEC[v][2*W-1:W], VEC[v][W-1:0]);

      // R9: abort in the middle of readback
      up_sample  = 18'h15555;
      uut_sample = 18'h3C3C3;
      start_conv();
      repeat (UP_CYC + 2) @(negedge clk);
      for (int i = 0; i < 5; i++) sck_pulse(b);
      check(b == 1'b0, "R7 bit 13 of 3C3C3", 32'(b), 0);
      @(negedge clk) cnv = 1'b0;
      @(negedge clk);
      check(sdo == 1'b0, "R9 abort mid read", 32'(sdo), 0);
      for (int i = 0; i < 3; i++) begin
         sck_pulse(b);
         check(b == 1'b0, "R9 sck ignored after end", 32'(b), 0);
      end

      // R1: reset during readback
      start_conv();
      repeat (UP_CYC + 2) @(negedge clk);
      sck_pulse(b);
      check(b == 1'b1, "R6 MSB of 3C3C3", 32'(b), 1);
      rst = 1'b1;
      @(negedge clk);
      check(sdo == 1'b0, "R1 reset mid read", 32'(sdo), 0);
      cnv = 1'b0;
      sck = 1'b0;
      @(negedge clk) rst = 1'b0;
      @(negedge clk);
      check(sdo == 1'b0, "R1 idle after reset", 32'(sdo), 0);

      // chain still works after reset
      run_vector(18'h0F0F0, 18'h33333);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule